// File: doc/BRIEF.md
# Big-Endian Load/Store Lane Unit

This block sits between a 32-bit processor core and a word-wide, big-endian data memory. On the store side it is purely combinational. It takes an access size, the two low address bits and a register value. From these it produces a four-bit byte-enable mask and write data in which each byte sits on the lane that its address selects. In this mapping the lowest byte address uses bits 31:24 and mask bit 3.

On the load side it takes a request strobe, the size, a signedness flag, the two low address bits and the word returned by memory. It extracts the addressed byte or halfword, extends it to 32 bits and registers the result. The result appears one cycle later together with a valid strobe.

Both paths check alignment. A misaligned store is suppressed by an all-zero mask. A misaligned load returns zero with a flag.

Top module: `lane_steer`

## Requirements
- R1: Size codes are 2'b00 byte, 2'b01 halfword, 2'b10 and 2'b11 word. An aligned word store drives `st_be` = 4'b1111 and `st_wdata` equal to `st_data`.
- R2: A halfword store at offset 0 drives `st_be` = 4'b1100 with `st_data[15:0]` in bits 31:16. At offset 2 it drives 4'b0011 with the halfword in bits 15:0. All unselected lanes of `st_wdata` are zero.
- R3: A byte store at offset 0, 1, 2 or 3 drives `st_be` = 4'b1000, 4'b0100, 4'b0010 or 4'b0001. `st_data[7:0]` is placed in bits 31:24, 23:16, 15:8 or 7:0, and the other lanes are zero.
- R4: A word store with a nonzero offset, or a halfword store with offset bit 0 set, raises `st_misal` and drives `st_be` = 4'b0000. `st_wdata` still carries the data on the lanes of the aligned-down address. Byte stores never raise `st_misal`.
- R5: `ld_valid` is high in exactly the cycle after a cycle in which `ld_req` was high. `ld_result` and `ld_misal` keep their values while no request is accepted.
- R6: A byte load selects bits 31:24, 23:16, 15:8 or 7:0 of `ld_word` for offsets 0 to 3. It is sign-extended when `ld_signed` is 1 and zero-extended when it is 0.
- R7: A halfword load selects bits 31:16 at offset 0 and bits 15:0 at offset 2, with the same extension rule as R6.
- R8: A word load at offset 0 returns `ld_word` unchanged, whatever the value of `ld_signed`.
- R9: A misaligned load, using the same rule as R4, returns `ld_result` = 0 with `ld_misal` = 1 in the valid cycle. Aligned loads return `ld_misal` = 0.
- R10: While `rst_n` is low, `ld_valid`, `ld_result` and `ld_misal` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_size | input | 2 | Store size code |
| st_off | input | 2 | Store address bits 1:0 |
| st_data | input | 32 | Store register value |
| st_be | output | 4 | Byte-enable mask, bit 3 is the lowest address |
| st_wdata | output | 32 | Lane-aligned write data |
| st_misal | output | 1 | Store alignment violation |
| ld_req | input | 1 | Load word presented this cycle |
| ld_size | input | 2 | Load size code |
| ld_signed | input | 1 | 1 for sign extension, 0 for zero extension |
| ld_off | input | 2 | Load address bits 1:0 |
| ld_word | input | 32 | Word read from memory |
| ld_valid | output | 1 | Load result valid |
| ld_result | output | 32 | Extended load value |
| ld_misal | output | 1 | Load alignment violation |

## Verification
The assertions check four properties on every cycle:
- a misaligned store never enables a byte;
- the number of enabled bytes matches the size;
- the valid strobe tracks the request by one cycle;
- unsigned byte loads and misaligned loads leave the expected bits zero.

Only the bench's scenarios can show the rest: which lane a given offset selects, where the store data lands, and whether the sign bit is taken from the right byte. The bench covers these by sweeping every size, offset and signedness combination with values whose top bits differ per lane. It then adds stretches of random traffic and idle cycles, which show that the result is held between requests.

// File: rtl/lane_steer.sv
module lane_steer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  st_size,
  input  logic [1:0]  st_off,
  input  logic [31:0] st_data,
  output logic [3:0]  st_be,
  output logic [31:0] st_wdata,
  output logic        st_misal,
  input  logic        ld_req,
  input  logic [1:0]  ld_size,
  input  logic        ld_signed,
  input  logic [1:0]  ld_off,
  input  logic [31:0] ld_word,
  output logic        ld_valid,
  output logic [31:0] ld_result,
  output logic        ld_misal
);

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;

  logic        st_is_word, st_is_half;
  logic [3:0]  be_raw;
  logic        ld_is_word, ld_is_half, ld_bad;
  logic [7:0]  ld_byte;
  logic [15:0] ld_half;
  logic [31:0] ld_next;

  assign st_is_word = st_size[1];
  assign st_is_half = (st_size == SZ_HALF);
  assign st_misal   = st_is_word ? |st_off : (st_is_half & st_off[0]);

  always_comb begin
    if (st_is_word) begin
      be_raw   = 4'b1111;
      st_wdata = st_data;
    end else if (st_is_half) begin
      be_raw   = st_off[1] ? 4'b0011 : 4'b1100;
      st_wdata = st_off[1] ? {16'h0, st_data[15:0]} : {st_data[15:0], 16'h0};
    end else begin
      be_raw   = 4'b1000 >> st_off;
      st_wdata = {st_data[7:0], 24'h0} >> {st_off, 3'b000};
    end
  end

  assign st_be = st_misal ? 4'b0000 : be_raw;

  assign ld_is_word = ld_size[1];
  assign ld_is_half = (ld_size == SZ_HALF);
  assign ld_bad     = ld_is_word ? |ld_off : (ld_is_half & ld_off[0]);
  assign ld_half    = ld_off[1] ? ld_word[15:0] : ld_word[31:16];

  always_comb begin
    case (ld_off)
      2'd0:    ld_byte = ld_word[31:24];
      2'd1:    ld_byte = ld_word[23:16];
      2'd2:    ld_byte = ld_word[15:8];
      default: ld_byte = ld_word[7:0];
    endcase
    if (ld_bad)
      ld_next = 32'h0;
    else if (ld_is_word)
      ld_next = ld_word;
    else if (ld_is_half)
      ld_next = {{16{ld_signed & ld_half[15]}}, ld_half};
    else
      ld_next = {{24{ld_signed & ld_byte[7]}}, ld_byte};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ld_valid  <= 1'b0;
      ld_result <= 32'h0;
      ld_misal  <= 1'b0;
    end else begin
      ld_valid <= ld_req;
      if (ld_req) begin
        ld_result <= ld_next;
        ld_misal  <= ld_bad;
      end
    end
  end

  AST_MISAL_STORE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    st_misal |-> (st_be == 4'b0000)); // R4

  AST_BE_WIDTH_MATCHES_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_be != 4'b0000) |-> ($countones(st_be) == (st_size[1] ? 4 : (st_size == SZ_HALF ? 2 : 1)))); // R1

  AST_BYTE_STORE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_size == SZ_BYTE) |-> $onehot0(st_be) && !st_misal); // R3

  AST_VALID_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ld_req |=> ld_valid); // R5

  AST_NO_VALID_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_req |=> !ld_valid); // R5

  AST_UNSIGNED_BYTE_ZERO_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_req && ld_size == SZ_BYTE && !ld_signed) |=> (ld_result[31:8] == 24'h0)); // R6

  AST_MISAL_LOAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_misal) |-> (ld_result == 32'h0)); // R9

endmodule

// File: tb/test_lane_steer.sv
module test_lane_steer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  st_size, st_off, ld_size, ld_off;
  logic [31:0] st_data, ld_word;
  logic        ld_req, ld_signed;
  logic [3:0]  st_be;
  logic [31:0] st_wdata, ld_result;
  logic        st_misal, ld_valid, ld_misal;

  int n_tests = 0;
  int n_fail  = 0;

  bit          q_v[$];
  logic [31:0] q_r[$];
  bit          q_m[$];
  string       q_t[$];
  logic [31:0] held_r = 32'h0;
  bit          held_m = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_steer i_lane_steer (
    .clk(clk), .rst_n(rst_n),
    .st_size(st_size), .st_off(st_off), .st_data(st_data),
    .st_be(st_be), .st_wdata(st_wdata), .st_misal(st_misal),
    .ld_req(ld_req), .ld_size(ld_size), .ld_signed(ld_signed),
    .ld_off(ld_off), .ld_word(ld_word),
    .ld_valid(ld_valid), .ld_result(ld_result), .ld_misal(ld_misal)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int nbytes(input logic [1:0] s);
    return s[1] ? 4 : (s[0] ? 2 : 1);
  endfunction

  task automatic step(input logic [1:0] ss, input logic [1:0] so, input logic [31:0] sd,
                      input bit lr, input logic [1:0] ls, input bit sg,
                      input logic [1:0] lo, input logic [31:0] lw);
    int n, base;
    bit mis;
    logic [3:0]  be;
    logic [31:0] wd, val;
    string tag;
    @(negedge clk);
    chk("R5", {31'h0, ld_valid}, {31'h0, q_v.pop_front()});
    tag = q_t.pop_front();
    chk(tag, ld_result, q_r.pop_front());
    chk(tag, {31'h0, ld_misal}, {31'h0, q_m.pop_front()});
    st_size = ss; st_off = so; st_data = sd;
    ld_req = lr; ld_size = ls; ld_signed = sg; ld_off = lo; ld_word = lw;
    #1;
    n = nbytes(ss);
    base = int'(so) / n * n;
    mis = (int'(so) % n) != 0;
    be = 4'h0; wd = 32'h0;
    for (int k = 0; k < 4; k++) begin
      if (k >= base && k < base + n) begin
        wd[31 - 8*k -: 8] = sd[8*(n - 1 - (k - base)) +: 8];
        be[3 - k] = !mis;
      end
    end
    tag = mis ? "R4" : (n == 4 ? "R1" : (n == 2 ? "R2" : "R3"));
    chk(tag, {28'h0, st_be}, {28'h0, be});
    chk(tag, st_wdata, wd);
    chk("R4", {31'h0, st_misal}, {31'h0, mis});
    if (lr) begin
      n = nbytes(ls);
      base = int'(lo) / n * n;
      mis = (int'(lo) % n) != 0;
      val = 32'h0;
      for (int i = 0; i < n; i++) val = (val << 8) | 32'(lw[31 - 8*(base + i) -: 8]);
      if (sg && n < 4 && val[8*n - 1]) val = val | (32'hFFFF_FFFF << (8*n));
      if (mis) val = 32'h0;
      held_r = val; held_m = mis;
      tag = mis ? "R9" : (n == 4 ? "R8" : (n == 2 ? "R7" : "R6"));
    end else begin
      tag = "R5";
    end
    q_v.push_back(lr); q_r.push_back(held_r); q_m.push_back(held_m); q_t.push_back(tag);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    st_size = 2'b00; st_off = 2'b00; st_data = 32'h0;
    ld_req = 1'b0; ld_size = 2'b00; ld_signed = 1'b0; ld_off = 2'b00; ld_word = 32'h0;
    repeat (2) @(posedge clk);
    ld_req = 1'b1; ld_word = 32'hFFFF_FFFF;
    @(posedge clk);
    @(negedge clk);
    chk("R10", {31'h0, ld_valid}, 32'h0);
    chk("R10", ld_result, 32'h0);
    chk("R10", {31'h0, ld_misal}, 32'h0);
    ld_req = 1'b0;
    rst_n = 1'b1;
    q_v.push_back(1'b0); q_r.push_back(32'h0); q_m.push_back(1'b0); q_t.push_back("R10");

    for (int s = 0; s < 4; s++)
      for (int o = 0; o < 4; o++)
        for (int g = 0; g < 2; g++)
          step(2'(s), 2'(o), 32'h8A7B_C6F5, 1'b1, 2'(s), g[0], 2'(o), 32'h81_42_E3_74);

    step(2'b00, 2'b10, 32'h0000_0080, 1'b1, 2'b00, 1'b1, 2'b10, 32'h0000_8000);
    step(2'b01, 2'b00, 32'h1234_FFFF, 1'b0, 2'b00, 1'b0, 2'b00, 32'h0);
    step(2'b10, 2'b00, 32'hDEAD_BEEF, 1'b0, 2'b10, 1'b1, 2'b01, 32'hFFFF_FFFF);
    step(2'b01, 2'b10, 32'h0000_7FFF, 1'b1, 2'b01, 1'b1, 2'b00, 32'h7FFF_8000);
    step(2'b11, 2'b00, 32'h0BAD_F00D, 1'b1, 2'b01, 1'b1, 2'b10, 32'h7FFF_8000);

    for (int i = 0; i < 400; i++)
      step(2'($urandom), 2'($urandom), $urandom, 1'($urandom), 2'($urandom),
           1'($urandom), 2'($urandom), $urandom);

    step(2'b00, 2'b00, 32'h0, 1'b0, 2'b00, 1'b0, 2'b00, 32'h0);
    step(2'b00, 2'b00, 32'h0, 1'b0, 2'b00, 1'b0, 2'b00, 32'h0);
    finish_run();
  end
endmodule